// File: doc/BRIEF.md
# Subcode Q CRC Serial Reader

This block takes the subcode Q channel of a disc decoder one bit at a time. A block-start strobe marks each 96-bit Q word: 80 data bits followed by a 16-bit check field. The block runs a CRC over the data bits and compares the result with the received check field. Only a word whose check matches is offered to the host. A word that fails is dropped without any visible trace.

An accepted word waits in a shadow register and moves into an output shift register only when no host read is in progress. When it moves, the ready flag rises. The host then holds a read-select line high and toggles its own slow clock. Each rising edge of that clock advances the serial output by one bit, least significant bit first. Both host signals are asynchronous to the system clock, so the block synchronizes them with a chain of flops. Host edges are detected inside the system clock domain.

Top module: `subq_crc_reader`

## Requirements
- R1: The CRC is CRC-16 with polynomial 0x1021 and an initial value of zero. It is computed over the 80 data bits in arrival order; each step shifts left and feeds back register bit 15 XOR the incoming bit. The 16 check bits arrive most significant first. Their bitwise inverse must equal the computed CRC before the ready flag (q_ready_o = 1) is raised.
- R2: A word whose check does not match is discarded. q_ready_o keeps its value, and a word already loaded for the host stays unchanged.
- R3: The first data bit received is bit 79 of the word and the last is bit 0. q_sdata_o presents bit 0 first, then bits 1 to 79 in order.
- R4: A pulse on q_blk_start_i starts a new word. If a bit is valid in the same cycle as the pulse, it is taken as the first bit of the word. Valid bits that arrive before any start pulse, or after the 96th bit, are ignored until the next pulse.
- R5: When no read is in progress, q_ready_o is high by the third system clock edge after the edge that samples the 96th bit of a word that passes the check.
- R6: q_ready_o clears on the first rising edge of host_clk_i seen while host_sel_i is high.
- R7: Each rising edge of host_clk_i while host_sel_i is high advances q_sdata_o by one bit; q_sdata_o does not change between such edges. Edges of host_clk_i while host_sel_i is low have no effect on the data or on q_ready_o.
- R8: A word accepted while host_sel_i is high is held, and it is loaded only after host_sel_i goes low. If several words are accepted during one read, the newest one is loaded.
- R9: Host clock phases of at least four system clock periods are tracked. q_sdata_o is valid no more than four system clocks after the host edge that advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_bit_i | input | 1 | Subcode Q serial bit |
| q_bit_valid_i | input | 1 | Marks q_bit_i as valid in this cycle |
| q_blk_start_i | input | 1 | Strobe at the first bit of a subcode block |
| host_clk_i | input | 1 | Host read clock, asynchronous |
| host_sel_i | input | 1 | Host read select, high while a read is in progress |
| q_ready_o | output | 1 | A CRC-valid word is waiting for the host |
| q_sdata_o | output | 1 | Serial data to the host, LSB first |

## Verification
Two functions can fall on the same clock edge. One is the acceptance of a newly checked word into the shadow register. The other is the release of a read, when the synchronized select falls and the shadow is copied into the output register. The bench holds the read select high across the arrival of a second word and lowers it at six different offsets around the word's last bit, so the copy lands before, on and after the acceptance edge. In every case the ready flag must rise and the serial read must return the new word. A second case, with two words arriving during one read, must return the later of the two.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned Q_DATA_W   = 80;
  localparam int unsigned Q_CRC_W    = 16;
  localparam logic [15:0] Q_CRC_POLY = 16'h1021;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/subq_crc_rx.sv
module subq_crc_rx #(
  parameter int unsigned DATA_W = subq_pkg::Q_DATA_W,
  parameter int unsigned CRC_W  = subq_pkg::Q_CRC_W,
  parameter logic [CRC_W-1:0] POLY = subq_pkg::Q_CRC_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              blk_start_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned FRAME_W = DATA_W + CRC_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  cnt_q, cnt_eff;
  logic [CRC_W-1:0]  crc_q, crc_base, crc_nxt, chk_q, chk_full;
  logic [DATA_W-1:0] data_q;
  logic              active, in_data, last, match;

  always_comb begin
    cnt_eff  = blk_start_i ? '0 : cnt_q;
    crc_base = blk_start_i ? '0 : crc_q;
    active   = bit_valid_i && (cnt_eff < CNT_END);
    in_data  = cnt_eff < CNT_DATA;
    last     = cnt_eff == CNT_LAST;
    crc_nxt  = {crc_base[CRC_W-2:0], 1'b0} ^ ((crc_base[CRC_W-1] ^ bit_i) ? POLY : '0);
    chk_full = {chk_q[CRC_W-2:0], bit_i};
    match    = (~chk_full) == crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_END;
      crc_q    <= '0;
      chk_q    <= '0;
      data_q   <= '0;
      word_o   <= '0;
      accept_o <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      if (active) begin
        cnt_q <= cnt_eff + 1'b1;
        if (in_data) begin
          crc_q  <= crc_nxt;
          data_q <= {data_q[DATA_W-2:0], bit_i};
        end else begin
          chk_q <= chk_full;
          if (last && match) begin
            accept_o <= 1'b1;
            word_o   <= data_q;
          end
        end
      end else if (blk_start_i) begin
        cnt_q <= '0;
        crc_q <= '0;
      end
    end
  end

  // R1: a word is accepted only once its frame is complete
  a_r1_accept_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> cnt_q == CNT_END);
  // R4: the bit counter never runs past the frame
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END);
endmodule

// File: rtl/subq_sync.sv
module subq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = subq_pkg::SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/subq_out_shift.sv
module subq_out_shift #(
  parameter int unsigned DATA_W = subq_pkg::Q_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              reading_i,
  input  logic              shift_i,
  output logic              ready_o,
  output logic              sdata_o
);
  logic [DATA_W-1:0] shadow_q, out_q;
  logic              shadow_full_q, load;

  assign load    = shadow_full_q && !reading_i;
  assign sdata_o = out_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q      <= '0;
      shadow_full_q <= 1'b0;
      out_q         <= '0;
      ready_o       <= 1'b0;
    end else begin
      if (accept_i) shadow_q <= word_i;
      // a fresh accept keeps the shadow full even on a load edge
      shadow_full_q <= accept_i || (shadow_full_q && !load);
      if (load) begin
        out_q   <= shadow_q;
        ready_o <= 1'b1;
      end else if (reading_i && shift_i) begin
        out_q   <= out_q >> 1;
        ready_o <= 1'b0;
      end
    end
  end

  // R6: the flag only drops on a host edge during a read
  a_r6_clear_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(reading_i && shift_i));
  // R7: data holds between host edges during a read
  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reading_i && !shift_i) |=> $stable(out_q));
  // R8: no new word is released while a read is in progress
  a_r8_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reading_i |=> !$rose(ready_o));
  // R8: a held word survives the read
  a_r8_shadow_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_full_q && reading_i) |=> shadow_full_q);
endmodule

// File: rtl/subq_crc_reader.sv
module subq_crc_reader #(
  parameter int unsigned DATA_W = subq_pkg::Q_DATA_W,
  parameter int unsigned CRC_W  = subq_pkg::Q_CRC_W,
  parameter logic [CRC_W-1:0] POLY = subq_pkg::Q_CRC_POLY,
  parameter int unsigned SYNC_STAGES = subq_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q_bit_i,
  input  logic q_bit_valid_i,
  input  logic q_blk_start_i,
  input  logic host_clk_i,
  input  logic host_sel_i,
  output logic q_ready_o,
  output logic q_sdata_o
);
  logic              accept;
  logic [DATA_W-1:0] word;
  logic [1:0]        host_sync;
  logic              hclk_prev_q, hclk_rise, reading;

  subq_crc_rx #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (q_bit_i),
    .bit_valid_i (q_bit_valid_i),
    .blk_start_i (q_blk_start_i),
    .accept_o    (accept),
    .word_o      (word)
  );

  subq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_sel_i, host_clk_i}),
    .sync_o  (host_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hclk_prev_q <= 1'b0;
    else         hclk_prev_q <= host_sync[0];
  end

  assign hclk_rise = host_sync[0] && !hclk_prev_q;
  assign reading   = host_sync[1];

  subq_out_shift #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .word_i    (word),
    .reading_i (reading),
    .shift_i   (hclk_rise),
    .ready_o   (q_ready_o),
    .sdata_o   (q_sdata_o)
  );

  // R9: one host edge is seen as exactly one shift pulse
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_rise |=> !hclk_rise);
  // R5: the flag rises only when no read holds the output
  a_r5_rise_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_ready_o) |-> !$past(reading));
endmodule

// File: tb/sim_subq_crc_reader.sv
module sim_subq_crc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic q_bit = 0, q_valid = 0, q_start = 0, host_clk = 0, host_sel = 0;
  logic q_ready, q_sdata;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subq_crc_reader u0 (
    .clk_i(clk), .rst_ni(rst_n), .q_bit_i(q_bit), .q_bit_valid_i(q_valid),
    .q_blk_start_i(q_start), .host_clk_i(host_clk), .host_sel_i(host_sel),
    .q_ready_o(q_ready), .q_sdata_o(q_sdata)
  );

  // bit 80 set: corrupt the check field
  localparam logic [DW:0] VEC [6] = '{
    {1'b0, 80'h0123_4567_89AB_CDEF_0246},
    {1'b1, 80'hFFFF_0000_FFFF_0000_FFFF},
    {1'b0, 80'h0000_0000_0000_0000_0001},
    {1'b0, 80'h8000_0000_0000_0000_0000},
    {1'b1, 80'h0000_0000_0000_0000_0000},
    {1'b0, 80'hA5A5_5A5A_C3C3_3C3C_F00F}
  };

  function automatic logic [15:0] ref_crc(input logic [DW-1:0] d);
    logic [15:0] c = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] d, input bit bad, input bit strobe, input int extra);
    logic [15:0] chkf = ~ref_crc(d) ^ (bad ? 16'h0010 : 16'h0000);
    for (int i = 0; i < 96 + extra; i++) begin
      @(negedge clk);
      q_start = strobe && (i == 0);
      q_valid = 1'b1;
      q_bit   = (i < DW) ? d[DW-1-i] : (i < 96) ? chkf[95-i] : i[0];
    end
    @(negedge clk);
    q_start = 0; q_valid = 0; q_bit = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_word(output logic [DW-1:0] d, input bit release_sel);
    d = '0;
    host_sel = 1'b1;
    repeat (4) @(negedge clk);
    d[0] = q_sdata;
    for (int i = 1; i < DW; i++) begin
      host_clk = 1'b1;
      repeat (4) @(negedge clk);
      if (i == 1) chk(DW'(q_ready), DW'(0), "R6 ready after first edge");
      host_clk = 1'b0;
      repeat (4) @(negedge clk);
      d[i] = q_sdata;
    end
    if (release_sel) begin
      host_sel = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd;
    logic [DW-1:0] wa = 80'h1357_9BDF_2468_ACE0_1122;
    logic [DW-1:0] wb = 80'hDEAD_BEEF_CAFE_F00D_7788;
    logic [DW-1:0] wc = 80'h0F1E_2D3C_4B5A_6978_8796;

    repeat (3) @(negedge clk);
    chk(DW'({q_ready, q_sdata}), DW'(0), "reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: no start strobe, valid frame ignored
    send_word(wa, 0, 0, 0);
    chk(DW'(q_ready), DW'(0), "R4 bits without start");

    // table walk: R1 R2 R3 R5
    foreach (VEC[k]) begin
      send_word(VEC[k][DW-1:0], VEC[k][DW], 1, 0);
      chk(DW'(q_ready), DW'(!VEC[k][DW]), "R1/R5 ready after block");
      if (!VEC[k][DW]) begin
        read_word(rd, 1);
        chk(rd, VEC[k][DW-1:0], "R3 serial LSB first");
      end
    end

    // R5 exact timing: ready on third edge after last bit
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      q_start = (i == 0); q_valid = 1'b1;
      q_bit = (i < DW) ? wa[DW-1-i] : ~ref_crc(wa) >> (95 - i);
    end
    @(negedge clk); q_start = 0; q_valid = 0; q_bit = 0;
    chk(DW'(q_ready), DW'(0), "R5 not yet after one edge");
    repeat (2) @(negedge clk);
    chk(DW'(q_ready), DW'(1), "R5 ready by third edge");

    // R2: corrupt word leaves loaded word intact
    send_word(wb, 1, 1, 0);
    chk(DW'(q_ready), DW'(1), "R2 ready kept");
    // R7: host edges with select low have no effect
    for (int i = 0; i < 3; i++) begin
      host_clk = 1; repeat (4) @(negedge clk);
      host_clk = 0; repeat (4) @(negedge clk);
    end
    chk(DW'(q_ready), DW'(1), "R7 ready unaffected");
    read_word(rd, 1);
    chk(rd, wa, "R2/R7 data unaffected");

    // R4: strobe with bit, trailing extra bits ignored
    send_word(wc, 0, 1, 20);
    chk(DW'(q_ready), DW'(1), "R4 ready with trailing bits");
    read_word(rd, 1);
    chk(rd, wc, "R4 trailing bits ignored");

    // R8: same-cycle acceptance and release, swept offsets
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] wn = wb ^ DW'(k);
      send_word(wa, 0, 1, 0);
      read_word(rd, 0);
      chk(rd, wa, "R8 first word");
      fork
        send_word(wn, 0, 1, 0);
        begin repeat (93 + k) @(negedge clk); host_sel = 1'b0; end
      join
      repeat (6) @(negedge clk);
      chk(DW'(q_ready), DW'(1), "R8 ready after release");
      read_word(rd, 1);
      chk(rd, wn, "R8 held word");
    end

    // R8: two words during one read, newest wins
    send_word(wa, 0, 1, 0);
    read_word(rd, 0);
    send_word(wb, 0, 1, 0);
    chk(DW'(q_ready), DW'(0), "R8 held during read");
    send_word(wc, 0, 1, 0);
    host_sel = 1'b0;
    repeat (6) @(negedge clk);
    read_word(rd, 1);
    chk(rd, wc, "R8 newest wins");

    // R9: minimum host phase of four system clocks
    send_word(wb, 0, 1, 0);
    host_sel = 1'b1;
    repeat (4) @(negedge clk);
    rd = '0; rd[0] = q_sdata;
    for (int i = 1; i < DW; i++) begin
      host_clk = 1; repeat (4) @(negedge clk);
      rd[i] = q_sdata;
      host_clk = 0; repeat (4) @(negedge clk);
    end
    host_sel = 1'b0;
    chk(rd, wb, "R9 fastest host clock");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule